// File: doc/BRIEF.md
# Bidirectional Single-Slot Flag Mailbox

This block sits between the bit-oriented processor and the byte-oriented processor of a dual-processor controller core. It moves control flags between them in both directions. Each direction has its own one-entry mailbox. The producing processor writes a flag word into it, and the consuming processor takes the word out. The two directions share nothing but the clock and the reset.

Each mailbox has two sides. The producer sees a `room` status that says a write will be accepted. The consumer sees a `ready` status that says an unread word is waiting. A consumer read acknowledges the transfer: the mailbox empties and the producer may write again. A write into a full slot is refused and flagged. A read from an empty slot is refused and flagged. Neither one disturbs the stored word or the word last delivered. Both flags are sticky. All status and the delivered word come from registers and change one cycle after the strobe that causes the change.

Top module: `flag_exchange`

## Requirements
- R1: In the cycle after reset is released, in both directions, `room` is 1, `ready` is 0, the delivered data word is 0 and both error flags are 0.
- R2: A write strobe while `room` is 1 stores the word. One cycle later `room` is 0 and the consumer's `ready` is 1.
- R3: A read strobe while `ready` is 1 (and no write in the same cycle) delivers the stored word. One cycle later the read data output shows the word, `ready` is 0 and `room` is 1.
- R4: A write strobe while `room` is 0, without a read in the same cycle, is ignored. The stored word is kept, and a later read returns the earlier word. One cycle later the producer's overflow flag is 1.
- R5: A read strobe while `ready` is 0 leaves the read data output unchanged. One cycle later the consumer's underflow flag is 1.
- R6: Write and read strobes together while the slot is full deliver the old word and store the new one. `ready` stays 1, `room` stays 0, and no error flag is raised.
- R7: Write and read strobes together while the slot is empty accept the write (`ready` becomes 1) and count the read as an underflow. The read data output is unchanged.
- R8: The two directions are independent. Activity in one direction changes no output of the other.
- R9: Overflow and underflow flags stay at 1 until reset, whatever traffic follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both processors |
| rst | input | 1 | Synchronous active-high reset |
| bit_wr_stb | input | 1 | Bit processor writes a flag word toward the byte processor |
| bit_wr_data | input | W | Flag word from the bit processor |
| bit_wr_room | output | 1 | Bit-to-byte slot is empty and may be written |
| bit_wr_ovf | output | 1 | Sticky: a bit-side write hit a full slot |
| byte_rd_stb | input | 1 | Byte processor takes the bit-to-byte word |
| byte_rd_data | output | W | Last word delivered to the byte processor |
| byte_rd_ready | output | 1 | Bit-to-byte slot holds an unread word |
| byte_rd_unf | output | 1 | Sticky: a byte-side read hit an empty slot |
| byte_wr_stb | input | 1 | Byte processor writes a flag word toward the bit processor |
| byte_wr_data | input | W | Flag word from the byte processor |
| byte_wr_room | output | 1 | Byte-to-bit slot is empty and may be written |
| byte_wr_ovf | output | 1 | Sticky: a byte-side write hit a full slot |
| bit_rd_stb | input | 1 | Bit processor takes the byte-to-bit word |
| bit_rd_data | output | W | Last word delivered to the bit processor |
| bit_rd_ready | output | 1 | Byte-to-bit slot holds an unread word |
| bit_rd_unf | output | 1 | Sticky: a bit-side read hit an empty slot |

## Verification
The properties assume that strobes are sampled at the clock edge and carry known values once reset is low. They also assume that a strobe held high for several cycles counts as a separate request in each cycle. The bench changes every strobe at the falling edge, holds each one for exactly one cycle, and asserts reset from time zero so that no property sees unknown inputs. Because the data-hold properties compare against the previous cycle, the bench leaves at least one edge after reset before it issues any strobe.

// File: rtl/flagx_pkg.sv
package flagx_pkg;

  localparam int unsigned NUM_DIR = 2;

  typedef enum logic [0:0] {
    DIR_BIT2BYTE = 1'b0,
    DIR_BYTE2BIT = 1'b1
  } flag_dir_e;

  // Decoded action of one slot in one cycle
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_FILL      = 3'd1,
    OP_DRAIN     = 3'd2,
    OP_PASS      = 3'd3,
    OP_REJECT    = 3'd4,
    OP_MISS      = 3'd5,
    OP_FILL_MISS = 3'd6
  } slot_op_e;

  function automatic slot_op_e decode_op(input logic full, input logic wr, input logic rd);
    slot_op_e op;
    if (full) begin
      if (wr && rd)      op = OP_PASS;
      else if (rd)       op = OP_DRAIN;
      else if (wr)       op = OP_REJECT;
      else               op = OP_IDLE;
    end else begin
      if (wr && rd)      op = OP_FILL_MISS;
      else if (wr)       op = OP_FILL;
      else if (rd)       op = OP_MISS;
      else               op = OP_IDLE;
    end
    return op;
  endfunction

endpackage

// File: rtl/flagx_ctrl.sv
module flagx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic rd_stb,
  output logic take_wr,
  output logic take_rd,
  output logic room,
  output logic ready,
  output logic ovf,
  output logic unf
);
  import flagx_pkg::*;

  slot_op_e op;
  logic     next_full;
  logic     ovf_ev;
  logic     unf_ev;
  logic     room_q, ready_q, ovf_q, unf_q;

  always_comb begin
    op      = decode_op(ready_q, wr_stb, rd_stb);
    take_wr = (op == OP_FILL) || (op == OP_PASS) || (op == OP_FILL_MISS);
    take_rd = (op == OP_DRAIN) || (op == OP_PASS);
    ovf_ev  = (op == OP_REJECT);
    unf_ev  = (op == OP_MISS) || (op == OP_FILL_MISS);
    unique case (op)
      OP_FILL, OP_FILL_MISS, OP_PASS, OP_REJECT: next_full = 1'b1;
      OP_DRAIN, OP_MISS:                         next_full = 1'b0;
      default:                                   next_full = ready_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      room_q  <= 1'b1;
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      room_q  <= ~next_full;
      ready_q <= next_full;
      ovf_q   <= ovf_q | ovf_ev;
      unf_q   <= unf_q | unf_ev;
    end
  end

  assign room  = room_q;
  assign ready = ready_q;
  assign ovf   = ovf_q;
  assign unf   = unf_q;

endmodule

// File: rtl/flagx_data.sv
module flagx_data #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_wr,
  input  logic         take_rd,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);

  logic [W-1:0] store_q;
  logic [W-1:0] out_q;

  // Read first: on a pass cycle the old word leaves before the new lands
  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      out_q   <= '0;
    end else begin
      if (take_rd) out_q   <= store_q;
      if (take_wr) store_q <= wr_data;
    end
  end

  assign rd_data = out_q;

endmodule

// File: rtl/flagx_slot.sv
module flagx_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  output logic         wr_room,
  output logic         wr_ovf,
  input  logic         rd_stb,
  output logic [W-1:0] rd_data,
  output logic         rd_ready,
  output logic         rd_unf
);

  logic take_wr;
  logic take_rd;

  flagx_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .take_wr (take_wr),
    .take_rd (take_rd),
    .room    (wr_room),
    .ready   (rd_ready),
    .ovf     (wr_ovf),
    .unf     (rd_unf)
  );

  flagx_data #(.W(W)) u_data (
    .clk     (clk),
    .rst     (rst),
    .take_wr (take_wr),
    .take_rd (take_rd),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/flag_exchange.sv
module flag_exchange #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_wr_stb,
  input  logic [W-1:0] bit_wr_data,
  output logic         bit_wr_room,
  output logic         bit_wr_ovf,
  input  logic         byte_rd_stb,
  output logic [W-1:0] byte_rd_data,
  output logic         byte_rd_ready,
  output logic         byte_rd_unf,
  input  logic         byte_wr_stb,
  input  logic [W-1:0] byte_wr_data,
  output logic         byte_wr_room,
  output logic         byte_wr_ovf,
  input  logic         bit_rd_stb,
  output logic [W-1:0] bit_rd_data,
  output logic         bit_rd_ready,
  output logic         bit_rd_unf
);
  import flagx_pkg::*;

  localparam int unsigned NDIR = NUM_DIR;

  logic [NDIR-1:0]         p_wr_stb, p_wr_room, p_wr_ovf;
  logic [NDIR-1:0]         c_rd_stb, c_rd_ready, c_rd_unf;
  logic [NDIR-1:0][W-1:0]  p_wr_data, c_rd_data;

  assign p_wr_stb[DIR_BIT2BYTE]  = bit_wr_stb;
  assign p_wr_data[DIR_BIT2BYTE] = bit_wr_data;
  assign c_rd_stb[DIR_BIT2BYTE]  = byte_rd_stb;
  assign p_wr_stb[DIR_BYTE2BIT]  = byte_wr_stb;
  assign p_wr_data[DIR_BYTE2BIT] = byte_wr_data;
  assign c_rd_stb[DIR_BYTE2BIT]  = bit_rd_stb;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    flagx_slot #(.W(W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_stb   (p_wr_stb[d]),
      .wr_data  (p_wr_data[d]),
      .wr_room  (p_wr_room[d]),
      .wr_ovf   (p_wr_ovf[d]),
      .rd_stb   (c_rd_stb[d]),
      .rd_data  (c_rd_data[d]),
      .rd_ready (c_rd_ready[d]),
      .rd_unf   (c_rd_unf[d])
    );
  end

  assign bit_wr_room   = p_wr_room[DIR_BIT2BYTE];
  assign bit_wr_ovf    = p_wr_ovf[DIR_BIT2BYTE];
  assign byte_rd_data  = c_rd_data[DIR_BIT2BYTE];
  assign byte_rd_ready = c_rd_ready[DIR_BIT2BYTE];
  assign byte_rd_unf   = c_rd_unf[DIR_BIT2BYTE];

  assign byte_wr_room  = p_wr_room[DIR_BYTE2BIT];
  assign byte_wr_ovf   = p_wr_ovf[DIR_BYTE2BIT];
  assign bit_rd_data   = c_rd_data[DIR_BYTE2BIT];
  assign bit_rd_ready  = c_rd_ready[DIR_BYTE2BIT];
  assign bit_rd_unf    = c_rd_unf[DIR_BYTE2BIT];

endmodule

// File: rtl/flag_exchange_chk.sv
module flag_exchange_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bit_wr_stb,
  input logic         bit_wr_room,
  input logic         bit_wr_ovf,
  input logic         byte_rd_stb,
  input logic [W-1:0] byte_rd_data,
  input logic         byte_rd_ready,
  input logic         byte_rd_unf,
  input logic         byte_wr_stb,
  input logic         byte_wr_room,
  input logic         byte_wr_ovf,
  input logic         bit_rd_stb,
  input logic [W-1:0] bit_rd_data,
  input logic         bit_rd_ready,
  input logic         bit_rd_unf
);

  // R2
  fill_b2y_chk: assert property (@(posedge clk) disable iff (rst)
    bit_wr_stb && bit_wr_room |=> byte_rd_ready && !bit_wr_room);

  // R2
  fill_y2b_chk: assert property (@(posedge clk) disable iff (rst)
    byte_wr_stb && byte_wr_room |=> bit_rd_ready && !byte_wr_room);

  // R3
  drain_b2y_chk: assert property (@(posedge clk) disable iff (rst)
    byte_rd_stb && byte_rd_ready && !bit_wr_stb |=> !byte_rd_ready && bit_wr_room);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    bit_wr_stb && !bit_wr_room && !byte_rd_stb |=> bit_wr_ovf && byte_rd_ready);

  // R5
  underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bit_rd_stb && !bit_rd_ready |=> bit_rd_unf && $stable(bit_rd_data));

  // R5
  underflow_hold_b2y_chk: assert property (@(posedge clk) disable iff (rst)
    byte_rd_stb && !byte_rd_ready |=> byte_rd_unf && $stable(byte_rd_data));

  // R6
  pass_keeps_ready_chk: assert property (@(posedge clk) disable iff (rst)
    byte_rd_stb && byte_rd_ready && bit_wr_stb |=> byte_rd_ready && !bit_wr_room && $stable(bit_wr_ovf));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bit_wr_ovf || byte_wr_ovf |=> $stable({bit_wr_ovf, byte_wr_ovf}) || $rose(bit_wr_ovf) || $rose(byte_wr_ovf));

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bit_rd_unf |=> bit_rd_unf);

  // R8
  dir_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_wr_stb && !bit_rd_stb |=> $stable(bit_rd_ready) && $stable(bit_rd_data));

endmodule

bind flag_exchange flag_exchange_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bit_wr_stb    (bit_wr_stb),
  .bit_wr_room   (bit_wr_room),
  .bit_wr_ovf    (bit_wr_ovf),
  .byte_rd_stb   (byte_rd_stb),
  .byte_rd_data  (byte_rd_data),
  .byte_rd_ready (byte_rd_ready),
  .byte_rd_unf   (byte_rd_unf),
  .byte_wr_stb   (byte_wr_stb),
  .byte_wr_room  (byte_wr_room),
  .byte_wr_ovf   (byte_wr_ovf),
  .bit_rd_stb    (bit_rd_stb),
  .bit_rd_data   (bit_rd_data),
  .bit_rd_ready  (bit_rd_ready),
  .bit_rd_unf    (bit_rd_unf)
);

// File: tb/flag_exchange_tb.sv
module flag_exchange_tb;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_wr_stb = 1'b0, byte_rd_stb = 1'b0, byte_wr_stb = 1'b0, bit_rd_stb = 1'b0;
  logic [W-1:0] bit_wr_data = '0, byte_wr_data = '0;
  logic bit_wr_room, bit_wr_ovf, byte_rd_ready, byte_rd_unf;
  logic byte_wr_room, byte_wr_ovf, bit_rd_ready, bit_rd_unf;
  logic [W-1:0] byte_rd_data, bit_rd_data;

  int checks = 0;
  int errors = 0;

  // Scoreboard: queued words per direction and expected sticky state
  logic [W-1:0] q_a[$];
  logic [W-1:0] q_b[$];
  logic [W-1:0] exp_a_rd, exp_b_rd;
  logic e_ovf_a, e_unf_a, e_ovf_b, e_unf_b;

  always #4 clk = ~clk;

  flag_exchange #(.W(W)) u_dut (
    .clk(clk), .rst(rst),
    .bit_wr_stb(bit_wr_stb), .bit_wr_data(bit_wr_data),
    .bit_wr_room(bit_wr_room), .bit_wr_ovf(bit_wr_ovf),
    .byte_rd_stb(byte_rd_stb), .byte_rd_data(byte_rd_data),
    .byte_rd_ready(byte_rd_ready), .byte_rd_unf(byte_rd_unf),
    .byte_wr_stb(byte_wr_stb), .byte_wr_data(byte_wr_data),
    .byte_wr_room(byte_wr_room), .byte_wr_ovf(byte_wr_ovf),
    .bit_rd_stb(bit_rd_stb), .bit_rd_data(bit_rd_data),
    .bit_rd_ready(bit_rd_ready), .bit_rd_unf(bit_rd_unf)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare every output against the scoreboard
  task automatic compare_all(input string tag);
    chk(bit_wr_room === (q_a.size() == 0), tag, "b2y room", W'(bit_wr_room), W'(q_a.size() == 0));
    chk(byte_rd_ready === (q_a.size() != 0), tag, "b2y ready", W'(byte_rd_ready), W'(q_a.size() != 0));
    chk(byte_rd_data === exp_a_rd, tag, "b2y data", byte_rd_data, exp_a_rd);
    chk(bit_wr_ovf === e_ovf_a, tag, "b2y ovf", W'(bit_wr_ovf), W'(e_ovf_a));
    chk(byte_rd_unf === e_unf_a, tag, "b2y unf", W'(byte_rd_unf), W'(e_unf_a));
    chk(byte_wr_room === (q_b.size() == 0), tag, "y2b room", W'(byte_wr_room), W'(q_b.size() == 0));
    chk(bit_rd_ready === (q_b.size() != 0), tag, "y2b ready", W'(bit_rd_ready), W'(q_b.size() != 0));
    chk(bit_rd_data === exp_b_rd, tag, "y2b data", bit_rd_data, exp_b_rd);
    chk(byte_wr_ovf === e_ovf_b, tag, "y2b ovf", W'(byte_wr_ovf), W'(e_ovf_b));
    chk(bit_rd_unf === e_unf_b, tag, "y2b unf", W'(bit_rd_unf), W'(e_unf_b));
  endtask

  // Driver: one cycle of strobes, scoreboard updated from the requirements
  task automatic tick(input logic bw, input logic [W-1:0] bwd, input logic yr,
                      input logic yw, input logic [W-1:0] ywd, input logic br,
                      input string tag);
    logic fa, fb;
    fa = (q_a.size() != 0);
    fb = (q_b.size() != 0);
    if (yr) begin
      if (fa) exp_a_rd = q_a.pop_front();
      else    e_unf_a  = 1'b1;
    end
    if (bw) begin
      if (!fa || yr) q_a.push_back(bwd);
      else           e_ovf_a = 1'b1;
    end
    if (br) begin
      if (fb) exp_b_rd = q_b.pop_front();
      else    e_unf_b  = 1'b1;
    end
    if (yw) begin
      if (!fb || br) q_b.push_back(ywd);
      else           e_ovf_b = 1'b1;
    end
    bit_wr_stb = bw; bit_wr_data = bwd; byte_rd_stb = yr;
    byte_wr_stb = yw; byte_wr_data = ywd; bit_rd_stb = br;
    @(negedge clk);
    bit_wr_stb = 1'b0; byte_rd_stb = 1'b0; byte_wr_stb = 1'b0; bit_rd_stb = 1'b0;
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q_a.delete(); q_b.delete();
    exp_a_rd = '0; exp_b_rd = '0;
    e_ovf_a = 0; e_unf_a = 0; e_ovf_b = 0; e_unf_b = 0;
    @(negedge clk);
    compare_all("R1");
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2 then R3 on bit-to-byte
    tick(1, 8'hA5, 0, 0, 8'h00, 0, "R2");
    tick(0, 8'h00, 1, 0, 8'h00, 0, "R3");
    // R5: read of empty slot holds the data
    tick(0, 8'h00, 1, 0, 8'h00, 0, "R5");
    // R8: byte-to-bit traffic only
    tick(0, 8'h00, 0, 1, 8'h3C, 0, "R8");
    // R4: second write into full slot is dropped
    tick(0, 8'h00, 0, 1, 8'h77, 0, "R4");
    tick(0, 8'h00, 0, 0, 8'h00, 1, "R4");
    // R6: pass-through while full
    tick(1, 8'h11, 0, 0, 8'h00, 0, "R6");
    tick(1, 8'h22, 1, 0, 8'h00, 0, "R6");
    tick(0, 8'h00, 1, 0, 8'h00, 0, "R6");
    // R7: write and read together on an empty slot
    tick(0, 8'h00, 0, 1, 8'h5A, 1, "R7");
    tick(0, 8'h00, 0, 0, 8'h00, 1, "R7");
    // R9: flags stay set through idle and traffic
    for (int i = 0; i < 4; i++) tick(0, 8'h00, 0, 0, 8'h00, 0, "R9");
    tick(1, 8'h66, 1, 1, 8'h99, 1, "R9");
    // R8: mixed patterns in both directions
    for (int i = 0; i < 60; i++) begin
      tick(i[0], W'(i * 37 + 3), i[1] ^ i[2], i[2], W'(i * 11 + 5), i[0] ^ i[3], "R8");
    end
    // R1: reset mid-run clears everything
    do_reset();
    tick(1, 8'hC3, 0, 1, 8'h0F, 0, "R2");
    tick(0, 8'h00, 1, 0, 8'h00, 1, "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule